// File: doc/BRIEF.md
# Ramp-crossing time encoder

This block converts an analog level into a time interval rather than an amplitude code. It steps an 8-bit sawtooth code out to an external DAC. An external comparator reports whether the sensor voltage lies above that ramp. While the ramp is below the input, the comparator is high. When the ramp climbs past the input, the comparator falls. The block timestamps that fall against a free-running timer. It then reports how many timer ticks have elapsed since the ramp last restarted at code zero. Because the ramp slope is constant, the tick count is linear in the input voltage.

Only the first qualified fall in each ramp period is kept. Later comparator activity is ignored until the ramp restarts, so chatter near the crossing cannot create extra samples. If no fall occurs during a period, the block reports a flagged result at the restart. This happens when the input is at or below the ramp start, or above the ramp's last code. A parameter selects a fast ramp variant or a slow ramp variant, so the same block can serve mains-frequency signals or slow physiological signals.

Top module: `ramp_tdc`

## Requirements
- R1: The DAC code for ramp step k is floor(k*256/STEPS). The step index advances every DIV clocks, and after step STEPS-1 it returns to 0, so a ramp period lasts STEPS*DIV clocks. After reset the code is 0.
- R2: The timer is CNT_W bits wide and increments once every TICK_DIV clocks. After reaching TMR_MAX it returns to 0. Only reset clears it; a capture never does.
- R3: A high-to-low transition of the comparator, seen through a two-flop synchronizer, captures the timer value two clocks after the comparator input fell. With the bench settings (DIV=4, TICK_DIV=2), a fall at the start of step j reports 2*j+1 ticks.
- R4: Exactly one result appears per ramp period, as a ts_valid strobe one clock wide.
- R5: Once a capture has been taken in a period, further comparator transitions in that period produce no output and do not change the reported value.
- R6: If no capture occurs in a period, then at the restart clock ts_valid pulses with ts_nocross=1 and ts_ticks=0. A captured result has ts_nocross=0.
- R7: The reported value is (capture time minus restart time) modulo TMR_MAX+1, so it is correct when the timer wraps within the period.
- R8: SLOW_SEL=1 selects SLOW_STEPS steps of SLOW_DIV clocks; SLOW_SEL=0 selects FAST_STEPS steps of FAST_DIV clocks.
- R9: A higher input level never gives a smaller tick count. Each extra ramp step adds DIV/TICK_DIV ticks.
- R10: During and right after reset, ts_valid and ts_nocross are 0 and dac_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_in | input | 1 | Asynchronous comparator output, high while the sensor is above the ramp |
| dac_code | output | 8 | Sawtooth code to the external DAC |
| ts_valid | output | 1 | One-clock strobe per ramp period |
| ts_ticks | output | CNT_W | Ticks from ramp restart to capture |
| ts_nocross | output | 1 | Result carries no crossing |

## Verification
The assertions assume that the comparator input settles at least three clocks before the ramp ends. The parameters therefore need DIV of at least 4, so that a fall in the final step is captured before the restart. The assertions also assume that the input does not drop at the very instant the ramp restarts. The bench stimulus respects both assumptions. Its comparator is a threshold compare against the DAC code, using DIV=4. It changes the level only at a ramp restart, and it never follows an above-full-scale level directly with a zero level. Chatter is injected only after the first capture and ends well before the restart.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned CODE_W = 8;

  // sawtooth code for one ramp step
  function automatic logic [CODE_W-1:0] ramp_code(input int unsigned idx, input int unsigned steps);
    int unsigned scaled;
    scaled = (idx * (1 << CODE_W)) / steps;
    return scaled[CODE_W-1:0];
  endfunction

  // elapsed ticks between two timer readings on a timer of the given modulus
  function automatic int unsigned span_ticks(input int unsigned now_v, input int unsigned ref_v,
                                             input int unsigned modulus);
    if (now_v >= ref_v) return now_v - ref_v;
    return now_v + modulus - ref_v;
  endfunction
endpackage

// File: rtl/rtc_ramp_seq.sv
module rtc_ramp_seq #(
  parameter int unsigned STEPS = 200,
  parameter int unsigned DIV   = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic [rtc_pkg::CODE_W-1:0] dac_code,
  output logic                       step_tick,
  output logic                       ramp_wrap
);
  localparam int unsigned SW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic [SW-1:0] step_q;

  assign step_tick = (div_q == DW'(DIV - 1));
  assign ramp_wrap = step_tick && (step_q == SW'(STEPS - 1));
  assign dac_code  = rtc_pkg::ramp_code(32'(step_q), STEPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      step_q <= '0;
    end else begin
      div_q <= step_tick ? '0 : div_q + 1'b1;
      if (ramp_wrap)      step_q <= '0;
      else if (step_tick) step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_timer.sv
module rtc_timer #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TICK_DIV = 2,
  parameter int unsigned TMR_MAX  = 65534
) (
  input  logic             clk,
  input  logic             rst,
  output logic             tick_en,
  output logic [CNT_W-1:0] tmr_q,
  output logic [CNT_W-1:0] tmr_nxt
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick_en = (pre_q == PW'(TICK_DIV - 1));
  assign tmr_nxt = !tick_en ? tmr_q :
                   (tmr_q == CNT_W'(TMR_MAX)) ? '0 : tmr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else begin
      pre_q <= tick_en ? '0 : pre_q + 1'b1;
      tmr_q <= tmr_nxt;
    end
  end
endmodule

// File: rtl/rtc_fall_detect.sv
module rtc_fall_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic comp_async,
  output logic fall_pulse
);
  // stages 0..SYNC_STAGES-1 synchronize, the last one holds the previous value
  logic [SYNC_STAGES:0] sh_q;

  assign fall_pulse = sh_q[SYNC_STAGES] && !sh_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], comp_async};
  end
endmodule

// File: rtl/ramp_tdc.sv
module ramp_tdc #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TMR_MAX    = 65534,
  parameter int unsigned TICK_DIV   = 2,
  parameter int unsigned FAST_STEPS = 200,
  parameter int unsigned FAST_DIV   = 128,
  parameter int unsigned SLOW_STEPS = 1250,
  parameter int unsigned SLOW_DIV   = 320,
  parameter bit          SLOW_SEL   = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       comp_in,
  output logic [rtc_pkg::CODE_W-1:0] dac_code,
  output logic                       ts_valid,
  output logic [CNT_W-1:0]           ts_ticks,
  output logic                       ts_nocross
);
  localparam int unsigned STEPS = SLOW_SEL ? SLOW_STEPS : FAST_STEPS;
  localparam int unsigned DIV   = SLOW_SEL ? SLOW_DIV : FAST_DIV;

  logic             step_tick, ramp_wrap, tick_en, fall_pulse;
  logic [CNT_W-1:0] tmr_q, tmr_nxt, base_q;
  logic             armed_q;
  logic             capture_hit;

  rtc_ramp_seq #(.STEPS(STEPS), .DIV(DIV)) u_seq (
    .clk(clk), .rst(rst), .dac_code(dac_code),
    .step_tick(step_tick), .ramp_wrap(ramp_wrap)
  );

  rtc_timer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .TMR_MAX(TMR_MAX)) u_tmr (
    .clk(clk), .rst(rst), .tick_en(tick_en), .tmr_q(tmr_q), .tmr_nxt(tmr_nxt)
  );

  rtc_fall_detect #(.SYNC_STAGES(2)) u_fall (
    .clk(clk), .rst(rst), .comp_async(comp_in), .fall_pulse(fall_pulse)
  );

  assign capture_hit = fall_pulse && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b1;
      base_q     <= '0;
      ts_valid   <= 1'b0;
      ts_ticks   <= '0;
      ts_nocross <= 1'b0;
    end else begin
      ts_valid   <= 1'b0;
      ts_nocross <= 1'b0;
      if (capture_hit) begin
        ts_valid <= 1'b1;
        ts_ticks <= CNT_W'(rtc_pkg::span_ticks(32'(tmr_q), 32'(base_q), TMR_MAX + 1));
        armed_q  <= 1'b0;
      end
      if (ramp_wrap) begin
        base_q  <= tmr_nxt;
        armed_q <= 1'b1;
        if (armed_q && !capture_hit) begin
          ts_valid   <= 1'b1;
          ts_nocross <= 1'b1;
          ts_ticks   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TMR_MAX = 65534
) (
  input logic             clk,
  input logic             rst,
  input logic             step_tick,
  input logic [7:0]       dac_code,
  input logic             tick_en,
  input logic [CNT_W-1:0] tmr_q,
  input logic             fall_pulse,
  input logic             armed_q,
  input logic             ts_valid,
  input logic             ts_nocross,
  input logic [CNT_W-1:0] ts_ticks
);
  // R1
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(dac_code));
  // R2
  tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && tmr_q != CNT_W'(TMR_MAX)) |=> (tmr_q == $past(tmr_q) + 1'b1));
  // R2
  tmr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && tmr_q == CNT_W'(TMR_MAX)) |=> (tmr_q == '0));
  // R2
  tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(tmr_q));
  // R3
  capture_out_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_pulse && armed_q) |=> (ts_valid && !ts_nocross));
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ts_valid |=> !ts_valid);
  // R5
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_pulse && !armed_q && !step_tick) |=> !ts_valid);
  // R6
  nocross_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ts_valid && ts_nocross) |-> (ts_ticks == '0));
endmodule

bind ramp_tdc rtc_chk #(.CNT_W(CNT_W), .TMR_MAX(TMR_MAX)) u_chk (
  .clk(clk), .rst(rst), .step_tick(step_tick), .dac_code(dac_code),
  .tick_en(tick_en), .tmr_q(tmr_q), .fall_pulse(fall_pulse), .armed_q(armed_q),
  .ts_valid(ts_valid), .ts_nocross(ts_nocross), .ts_ticks(ts_ticks)
);

// File: tb/sim_ramp_tdc.sv
module sim_ramp_tdc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int lvl0 = 0, lvl1 = 0;
  logic chat0 = 1'b0;
  logic [7:0] dac0, dac1;
  logic v0, v1, nc0, nc1;
  logic [15:0] t0, t1;
  logic comp0, comp1;

  assign comp0 = (lvl0 > int'(dac0)) || chat0;
  assign comp1 = (lvl1 > int'(dac1));

  ramp_tdc #(.TMR_MAX(999), .TICK_DIV(2), .FAST_STEPS(200), .FAST_DIV(4), .SLOW_SEL(1'b0)) u0 (
    .clk(clk), .rst(rst), .comp_in(comp0), .dac_code(dac0),
    .ts_valid(v0), .ts_ticks(t0), .ts_nocross(nc0));

  ramp_tdc #(.TICK_DIV(2), .SLOW_STEPS(1250), .SLOW_DIV(4), .SLOW_SEL(1'b1)) u1 (
    .clk(clk), .rst(rst), .comp_in(comp1), .dac_code(dac1),
    .ts_valid(v1), .ts_ticks(t1), .ts_nocross(nc1));

  int checks = 0, errors = 0, cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp=below 190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one full ramp period on the chosen instance; level applied at its restart
  task automatic run_period(input bit sel, input int lvl, input bit chatter,
                            input string req, output int got);
    int steps, p, j, exp_t, cyc, nval, gdata, gnc;
    bit exp_nc;
    logic [7:0] prev, cur;
    steps = sel ? 1250 : 200;
    p = steps * 4;
    j = (lvl * steps + 255) / 256;
    exp_nc = (lvl <= 0) || (j >= steps);
    exp_t = exp_nc ? 0 : 2 * j + 1;
    prev = sel ? dac1 : dac0;
    forever begin
      @(negedge clk);
      cur = sel ? dac1 : dac0;
      if (cur == 8'd0 && prev != 8'd0) break;
      prev = cur;
    end
    if (sel) lvl1 = lvl; else lvl0 = lvl;
    cyc = 0; nval = 0; gdata = -1; gnc = -1;
    prev = 8'd0;
    forever begin
      @(negedge clk);
      cyc++;
      if (chatter)
        chat0 = ((cyc >= 4*j+10 && cyc < 4*j+16) || (cyc >= 4*j+22 && cyc < 4*j+28));
      if (sel ? v1 : v0) begin
        nval++;
        if (nval == 1) begin
          gdata = int'(sel ? t1 : t0);
          gnc = int'(sel ? nc1 : nc0);
        end
      end
      cur = sel ? dac1 : dac0;
      if (cur == 8'd0 && prev != 8'd0) break;
      prev = cur;
    end
    chat0 = 1'b0;
    chk(cyc == p, {req, " R1 period length"}, cyc, p);
    chk(nval == 1, {req, " R4 one strobe per period"}, nval, 1);
    chk(gnc == int'(exp_nc), {req, " R6 flag"}, gnc, int'(exp_nc));
    chk(gdata == exp_t, {req, " R3 ticks"}, gdata, exp_t);
    got = gdata;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(v0 == 1'b0, "R10 valid in reset", int'(v0), 0);
    chk(nc0 == 1'b0, "R10 flag in reset", int'(nc0), 0);
    chk(dac0 == 8'd0, "R10 code in reset", int'(dac0), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(v0 == 1'b0 && v1 == 1'b0, "R10 valid after reset", int'(v0), 0);
  endtask

  // R9 R7: rising sweep on the fast ramp, timer wraps every 1000 ticks
  task automatic t_sweep();
    int lv[9] = '{1, 20, 64, 100, 128, 150, 200, 240, 254};
    int prevd, d;
    prevd = -1;
    foreach (lv[i]) begin
      run_period(1'b0, lv[i], 1'b0, "sweep", d);
      chk(d > prevd, "R9 monotone ticks", d, prevd + 1);
      if (i > 0)
        chk(d - prevd == 2 * (((lv[i]*200+255)/256) - ((lv[i-1]*200+255)/256)),
            "R9 ticks per step", d - prevd,
            2 * (((lv[i]*200+255)/256) - ((lv[i-1]*200+255)/256)));
      prevd = d;
    end
  endtask

  // R7: repeat one high level over successive periods at shifting timer phase
  task automatic t_wrap();
    int d;
    for (int k = 0; k < 5; k++) begin
      run_period(1'b0, 230, 1'b0, "R7 timer wrap", d);
    end
  endtask

  task automatic t_nocross_high();
    int d;
    run_period(1'b0, 255, 1'b0, "R6 above full scale", d);
  endtask

  task automatic t_nocross_low();
    int d;
    run_period(1'b0, 50, 1'b0, "R6 spacer", d);
    run_period(1'b0, 0, 1'b0, "R6 below ramp start", d);
  endtask

  task automatic t_chatter();
    int d;
    run_period(1'b0, 40, 1'b1, "R5 chatter ignored", d);
    chk(d == 2 * ((40*200+255)/256) + 1, "R5 value unchanged", d, 2 * ((40*200+255)/256) + 1);
  endtask

  task automatic t_slow();
    int d;
    run_period(1'b1, 100, 1'b0, "R8 slow ramp", d);
    run_period(1'b1, 256, 1'b0, "R8 slow no crossing", d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sweep();
    t_wrap();
    t_nocross_high();
    t_nocross_low();
    t_chatter();
    t_slow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule